// File: doc/BRIEF.md
# Reference-Edge Timing Window Monitor

This block tells a host whether the rising edge of a periodic reference signal lands dangerously close to the sampling clock edge. Outside the block, the reference is captured six times at fixed, ordered instants spread over a window of about 100 ps. One of these is the main capture, which is the one the converter actually uses. The other five are taken slightly before and after it. The six bits reach this block as one parallel vector, qualified by a one-cycle valid strobe per sample set.

The block registers each sample set and XORs every pair of captures that are neighbours in time. A pair that disagrees means the reference transition fell between those two instants, so the capture may be metastable. The block also forms a summary bit from the flags. When the main capture shows a rising reference edge, the block loads the flags and the summary bit into a status byte that is not sticky, together with two constant bits. A host reads the byte through a small synchronous read port.

Top module: `ref_edge_window_mon`

## Requirements
- R1: After reset, the status byte holds 0x81 and `rd_data` is 0. A read of the status address returns 0x81 until the first reference rising edge is detected.
- R2: The capture vector is in time order, with bit 0 the earliest and bit 2 the main capture. Flag k (k = 1..5) is the XOR of capture bits k-1 and k, and it is stored in status bit k+1. For example, bits {0,0,1,1,1,1} from bit 0 upward read as 0x8B.
- R3: Status bit 1 is the OR of the five flags. It is 0 when all six captures agree.
- R4: Status bits 7 and 0 always read 1.
- R5: The status byte is loaded only when capture bit 2 of the current valid set is 1 and was 0 in the previous valid set. The register that holds the previous value resets to 0. Otherwise the byte keeps its value.
- R6: The status byte is not sticky. Each load replaces every flag and the summary bit, and flags set by the previous load are cleared.
- R7: A sample vector presented while `samp_valid` is 0 has no effect. It changes neither the status byte nor the edge-detection history.
- R8: `rd_data` is registered and appears one cycle after a read strobe. A strobe to the status address (default 0x22F) returns the status byte. A strobe to any other address returns 0, and a cycle with no strobe gives 0 on the next cycle.
- R9: Reads do not alter the status byte. Repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | Sample set valid, one cycle per set |
| samp_bits | input | 6 | Reference captures in time order; bit 2 is the main capture |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
The reference transition is placed between each pair of neighbouring captures in turn, which shows that every pair maps to its own status bit and that the example pattern reads 0x8B. An alternating capture pattern sets every flag at once. Uniform patterns check that the summary bit and all flags stay clear. Sets whose main capture stays high, stays low or falls check that only a true rising edge loads the byte. Vectors changed while the valid strobe is low separate real sample sets from noise on the bus. Reads to foreign addresses, idle cycles and repeated reads show that the port returns zero where it should and leaves the flags untouched.

// File: rtl/rew_pkg.sv
package rew_pkg;
  localparam int TAP_CNT   = 6;
  localparam int FLAG_CNT  = TAP_CNT - 1;
  localparam int MAIN_IDX  = 2;
  localparam int BYTE_W    = 8;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'h81;

  typedef logic [BYTE_W-1:0] stat_byte_t;

  function automatic stat_byte_t pack_byte(input logic [FLAG_CNT-1:0] fl,
                                           input logic any_set);
    stat_byte_t b;
    b = IDLE_BYTE;
    b[FLAG_CNT+1:2] = fl;
    b[1] = any_set;
    return b;
  endfunction
endpackage

// File: rtl/rew_capture.sv
module rew_capture #(
  parameter int TAPS = rew_pkg::TAP_CNT,
  parameter int MAIN = rew_pkg::MAIN_IDX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            samp_valid,
  input  logic [TAPS-1:0] samp_bits,
  output logic [TAPS-1:0] cap_q,
  output logic            ref_rise
);
  logic cap_vld_q;
  logic prev_main_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q       <= '0;
      cap_vld_q   <= 1'b0;
      prev_main_q <= 1'b0;
    end else begin
      cap_vld_q <= samp_valid;
      if (samp_valid) cap_q <= samp_bits;
      if (cap_vld_q) prev_main_q <= cap_q[MAIN];
    end
  end

  assign ref_rise = cap_vld_q & cap_q[MAIN] & ~prev_main_q;

  // R5: a detected edge cannot repeat on the very next cycle
  p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
    ref_rise |=> !ref_rise);
endmodule

// File: rtl/rew_xor_flags.sv
module rew_xor_flags #(
  parameter int TAPS = rew_pkg::TAP_CNT,
  localparam int NFL = TAPS - 1
) (
  input  logic [TAPS-1:0] cap,
  output logic [NFL-1:0]  flags,
  output logic            any_set
);
  for (genvar k = 0; k < NFL; k++) begin : g_pair
    assign flags[k] = cap[k] ^ cap[k+1];
  end
  assign any_set = |flags;
endmodule

// File: rtl/rew_status_reg.sv
module rew_status_reg #(
  parameter int NFL = rew_pkg::FLAG_CNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [NFL-1:0]     flags,
  input  logic               any_set,
  output rew_pkg::stat_byte_t status_q
);
  always_ff @(posedge clk) begin
    if (rst) status_q <= rew_pkg::IDLE_BYTE;
    else if (load) status_q <= rew_pkg::pack_byte(flags, any_set);
  end

  // R4: constant bits stay set
  p_fixed_bits_r4: assert property (@(posedge clk) disable iff (rst)
    status_q[7] && status_q[0]);
  // R3: summary agrees with stored flags
  p_summary_r3: assert property (@(posedge clk) disable iff (rst)
    status_q[1] == (|status_q[NFL+1:2]));
  // R5: no load, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(status_q));
  // R6: a load replaces every flag
  p_replace_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> status_q[NFL+1:2] == $past(flags));
endmodule

// File: rtl/rew_read_port.sv
module rew_read_port #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h22F
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  rew_pkg::stat_byte_t status,
  output rew_pkg::stat_byte_t rd_data
);
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en && rd_addr == STAT_ADDR) rd_data <= status;
    else rd_data <= '0;
  end

  // R8: foreign address reads as zero
  p_other_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != STAT_ADDR) |=> rd_data == '0);
  // R8: no strobe gives zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);
  // R9: a hit returns the byte held at the strobe
  p_hit_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == STAT_ADDR) |=> rd_data == $past(status));
endmodule

// File: rtl/ref_edge_window_mon.sv
module ref_edge_window_mon #(
  parameter int TAPS   = rew_pkg::TAP_CNT,
  parameter int MAIN   = rew_pkg::MAIN_IDX,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h22F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_valid,
  input  logic [TAPS-1:0]   samp_bits,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int NFL = TAPS - 1;

  logic [TAPS-1:0]     cap_q;
  logic                ref_rise;
  logic [NFL-1:0]      flags;
  logic                any_set;
  rew_pkg::stat_byte_t status_q;

  rew_capture #(.TAPS(TAPS), .MAIN(MAIN)) u_cap (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_bits(samp_bits),
    .cap_q(cap_q), .ref_rise(ref_rise));

  rew_xor_flags #(.TAPS(TAPS)) u_xor (
    .cap(cap_q), .flags(flags), .any_set(any_set));

  rew_status_reg #(.NFL(NFL)) u_stat (
    .clk(clk), .rst(rst), .load(ref_rise), .flags(flags),
    .any_set(any_set), .status_q(status_q));

  rew_read_port #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .status(status_q), .rd_data(rd_data));
endmodule

// File: tb/ref_edge_window_mon_tb.sv
module ref_edge_window_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] STAT = 12'h22F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        samp_valid = 1'b0;
  logic [5:0]  samp_bits = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_stat = 8'h81;
  logic       exp_prev = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_edge_window_mon u_dut (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_bits(samp_bits),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [7:0] model_byte(input logic [5:0] b);
    logic [7:0] r;
    r = 8'h81;
    for (int k = 0; k < 5; k++) r[k+2] = b[k] ^ b[k+1];
    r[1] = |r[6:2];
    return r;
  endfunction

  task automatic send_set(input logic [5:0] b);
    @(negedge clk);
    samp_valid = 1'b1;
    samp_bits  = b;
    @(negedge clk);
    samp_valid = 1'b0;
    if (b[2] && !exp_prev) exp_stat = model_byte(b);
    exp_prev = b[2];
    repeat (2) @(negedge clk);
  endtask

  task automatic noise_set(input logic [5:0] b);
    @(negedge clk);
    samp_valid = 1'b0;
    samp_bits  = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input logic [11:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle_check();
    repeat (2) @(negedge clk);
    checks++;
    if (rd_data !== 8'h00) begin
      fails++;
      $display("FAIL R8 idle: got %02h expected 00", rd_data);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      logic pend;
      @(posedge clk);
      pend = rd_en;
      #1;
      if (pend && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rd_data !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset rd_data: got %02h expected 00", rd_data);
    end
    do_read(STAT, 8'h81, "R1 reset status");

    // R2/R3: transition between captures 1 and 2 -> 0x8B
    send_set(6'b111100);
    do_read(STAT, 8'h8B, "R2 R3 flag2 example");
    do_read(12'h22E, 8'h00, "R8 other address");
    idle_check();
    do_read(STAT, 8'h8B, "R9 repeat read");

    // R5: main stays high, then low -> no load
    send_set(6'b111111);
    do_read(STAT, 8'h8B, "R5 main held high");
    send_set(6'b000000);
    do_read(STAT, 8'h8B, "R5 main low");

    // R6: new edge with flag1 only clears flag2
    send_set(6'b111110);
    do_read(STAT, 8'h87, "R6 flag1 replaces flag2");

    // R7: noise with valid low ignored
    send_set(6'b000000);
    noise_set(6'b000100);
    do_read(STAT, 8'h87, "R7 noise ignored");
    send_set(6'b000100);
    do_read(STAT, 8'h9B, "R7 R2 flags2 and 3 after valid");

    // R3: clean edge, summary clear
    send_set(6'b000000);
    send_set(6'b111111);
    do_read(STAT, 8'h81, "R3 no flags summary clear");

    // R2: flag4 and flag5 positions
    send_set(6'b000000);
    send_set(6'b001111);
    do_read(STAT, 8'hA3, "R2 flag4");
    send_set(6'b000000);
    send_set(6'b011111);
    do_read(STAT, 8'hC3, "R2 flag5");

    // R2/R4: all flags
    send_set(6'b000000);
    send_set(6'b010101);
    do_read(STAT, 8'hFF, "R2 R4 all flags");
    do_read(12'h000, 8'h00, "R8 address zero");
    do_read(STAT, exp_stat, "R9 model consistency");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 pending reads: got %0d expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule